// File: doc/BRIEF.md
# Character Console Register Block

This block sits on a 16-bit processor bus and exposes four device registers at fixed addresses. Two registers serve character input: a status word whose top bit says a character is waiting, and a data word that holds that character. Two registers serve character output: a status word whose top bit says the output side can take a character, and a data word that software writes to emit one.

On the input side, a character source offers a byte with a one-cycle strobe. The first offered byte is latched and the ready flag is raised. From then on the input is locked and further offered bytes are dropped. A bus read of the input data register unlocks it again. On the output side, a write to the output data register while the output is ready sends the low byte to a character sink with a one-cycle strobe and marks the output busy. The sink's acknowledge pulse makes the output ready again. Writes that arrive while the output is busy are dropped.

Bus accesses to the four addresses are claimed by the block through a hit flag, so memory ignores them. Read data is combinational, valid in the same cycle as the request.

Top module: `console_regs`

## Requirements
- R1: After reset, input status reads 0x0000, output status reads 0x8000, and input data reads 0x0000.
- R2: Register addresses: input status 0xFE00, input data 0xFE02, output status 0xFE04, output data 0xFE06. `bus_hit` is 1 exactly when a read or write strobe targets one of these four addresses. Reads of any other address return 0.
- R3: When `kb_valid` pulses while the input is unlocked, the input data register from the next cycle reads {8'h00, kb_char} and input status reads 0x8000.
- R4: While input status bit 15 is 1, `kb_valid` pulses are discarded, and input data keeps the first character.
- R5: A bus read of 0xFE02 clears input status bit 15 from the next cycle. A character offered after that read is accepted.
- R6: A write to 0xFE06 while output status bit 15 is 1 drives `disp_valid` high for one cycle with `disp_char` equal to the written bits [7:0]. From the next cycle output status reads 0x0000.
- R7: Writes to 0xFE06 while output status bit 15 is 0 produce no `disp_valid` pulse.
- R8: A `disp_ack` pulse sets output status back to 0x8000 from the next cycle.
- R9: Writes to 0xFE00, 0xFE02 and 0xFE04 change no register. Status bits [14:0] always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Bus word address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, same cycle |
| bus_hit | output | 1 | Access claimed by this block |
| kb_valid | input | 1 | Character offered by the source |
| kb_char | input | 8 | Offered character |
| disp_valid | output | 1 | Character sent to the sink |
| disp_char | output | 8 | Character sent to the sink |
| disp_ack | input | 1 | Sink finished the last character |

## Verification
Input is tried with a single offered character, with a burst offered while locked, and with an offer after the unlocking read. Together these separate latching from overwriting and show that only the data read unlocks the input; a status read does not. Output is tried with a write while ready, a second write while busy, and a write after the acknowledge. This separates gating by the ready flag from unconditional forwarding. Stray writes to the other three registers and reads of unmapped addresses check that decoding stays confined to the proper register.

// File: rtl/console_pkg.sv
package console_pkg;
  localparam int unsigned DW = 16;
  localparam int unsigned CW = 8;
  localparam logic [DW-1:0] A_KSTAT = 16'hFE00;
  localparam logic [DW-1:0] A_KDATA = 16'hFE02;
  localparam logic [DW-1:0] A_DSTAT = 16'hFE04;
  localparam logic [DW-1:0] A_DDATA = 16'hFE06;

  typedef enum logic [2:0] {SEL_NONE, SEL_KSTAT, SEL_KDATA, SEL_DSTAT, SEL_DDATA} sel_e;

  function automatic sel_e decode(input logic [DW-1:0] a);
    case (a)
      A_KSTAT: decode = SEL_KSTAT;
      A_KDATA: decode = SEL_KDATA;
      A_DSTAT: decode = SEL_DSTAT;
      A_DDATA: decode = SEL_DDATA;
      default: decode = SEL_NONE;
    endcase
  endfunction

  function automatic logic [DW-1:0] status_word(input logic flag);
    status_word = {flag, {(DW-1){1'b0}}};
  endfunction

  function automatic logic [DW-1:0] char_word(input logic [CW-1:0] c);
    char_word = {{(DW-CW){1'b0}}, c};
  endfunction
endpackage

// File: rtl/console_kb_side.sv
module console_kb_side
  import console_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          src_valid,
  input  logic [CW-1:0] src_char,
  input  logic          data_read,
  output logic          full,
  output logic [CW-1:0] held,
  output logic          accept_ev
);
  assign accept_ev = src_valid && !full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      held <= '0;
    end else begin
      if (accept_ev) begin
        held <= src_char;
        full <= 1'b1;
      end else if (data_read) begin
        full <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/console_disp_side.sv
module console_disp_side
  import console_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          data_write,
  input  logic [CW-1:0] wr_char,
  input  logic          ack,
  output logic          ready,
  output logic          send_ev,
  output logic [CW-1:0] send_char
);
  assign send_ev   = data_write && ready;
  assign send_char = wr_char;

  always_ff @(posedge clk) begin
    if (!rst_n)        ready <= 1'b1;
    else if (send_ev)  ready <= 1'b0;
    else if (ack)      ready <= 1'b1;
  end
endmodule

// File: rtl/console_regs.sv
module console_regs
  import console_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [15:0]   bus_addr,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [15:0]   bus_wdata,
  output logic [15:0]   bus_rdata,
  output logic          bus_hit,
  input  logic          kb_valid,
  input  logic [7:0]    kb_char,
  output logic          disp_valid,
  output logic [7:0]    disp_char,
  input  logic          disp_ack
);
  sel_e          sel;
  logic          kdata_rd_ev, ddata_wr_ev;
  logic          kb_full, kb_accept_ev;
  logic [CW-1:0] kb_held;
  logic          dp_ready;

  assign sel         = decode(bus_addr);
  assign bus_hit     = (bus_rd || bus_wr) && (sel != SEL_NONE);
  assign kdata_rd_ev = bus_rd && (sel == SEL_KDATA);
  assign ddata_wr_ev = bus_wr && (sel == SEL_DDATA);

  console_kb_side u_kb (
    .clk(clk), .rst_n(rst_n), .src_valid(kb_valid), .src_char(kb_char),
    .data_read(kdata_rd_ev), .full(kb_full), .held(kb_held), .accept_ev(kb_accept_ev)
  );

  console_disp_side u_dp (
    .clk(clk), .rst_n(rst_n), .data_write(ddata_wr_ev), .wr_char(bus_wdata[CW-1:0]),
    .ack(disp_ack), .ready(dp_ready), .send_ev(disp_valid), .send_char(disp_char)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (sel)
        SEL_KSTAT: bus_rdata = status_word(kb_full);
        SEL_KDATA: bus_rdata = char_word(kb_held);
        SEL_DSTAT: bus_rdata = status_word(dp_ready);
        default:   bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/console_regs_checker.sv
module console_regs_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        kb_valid,
  input logic        kb_full,
  input logic        kb_accept_ev,
  input logic        kdata_rd_ev,
  input logic        ddata_wr_ev,
  input logic        dp_ready,
  input logic        disp_valid,
  input logic        disp_ack,
  input logic [15:0] bus_rdata,
  input logic        bus_rd
);
  p_accept_sets_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    kb_accept_ev |=> kb_full);
  p_locked_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (kb_full && kb_valid) |-> !kb_accept_ev);
  p_read_unlocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (kdata_rd_ev && !kb_accept_ev) |=> !kb_full);
  p_send_busies_r6: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |=> !dp_ready);
  p_busy_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ddata_wr_ev && !dp_ready) |-> !disp_valid);
  p_ack_readies_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_ack && !disp_valid) |=> dp_ready);
  p_low_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |-> (bus_rdata[14:8] == 7'd0));
endmodule

bind console_regs console_regs_checker u_chk (
  .clk(clk), .rst_n(rst_n), .kb_valid(kb_valid), .kb_full(kb_full),
  .kb_accept_ev(kb_accept_ev), .kdata_rd_ev(kdata_rd_ev), .ddata_wr_ev(ddata_wr_ev),
  .dp_ready(dp_ready), .disp_valid(disp_valid), .disp_ack(disp_ack),
  .bus_rdata(bus_rdata), .bus_rd(bus_rd)
);

// File: tb/console_regs_bench.sv
`timescale 1ns/1ps
module console_regs_bench;
  logic clk = 0, rst_n = 0;
  logic [15:0] bus_addr = 0, bus_wdata = 0;
  logic bus_rd = 0, bus_wr = 0, kb_valid = 0, disp_ack = 0;
  logic [7:0] kb_char = 0;
  logic [15:0] bus_rdata;
  logic bus_hit, disp_valid;
  logic [7:0] disp_char;
  int checks = 0, errors = 0;
  int sends = 0;
  logic [7:0] last_sent;

  always #2 clk = ~clk;

  console_regs u_console_regs (.*);

  always @(posedge clk) if (rst_n && disp_valid) begin sends++; last_sent <= disp_char; end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [15:0] a, output logic [15:0] d, output logic hit);
    @(negedge clk); bus_addr = a; bus_rd = 1; #1; d = bus_rdata; hit = bus_hit;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic offer(input logic [7:0] c);
    @(negedge clk); kb_char = c; kb_valid = 1;
    @(negedge clk); kb_valid = 0;
  endtask

  task automatic ack();
    @(negedge clk); disp_ack = 1;
    @(negedge clk); disp_ack = 0;
  endtask

  task automatic t_reset();
    logic [15:0] d; logic h;
    rd(16'hFE00, d, h); chk("R1 kstat", d, 16'h0000); chk("R2 hit", h, 1);
    rd(16'hFE04, d, h); chk("R1 dstat", d, 16'h8000);
    rd(16'hFE02, d, h); chk("R1 kdata", d, 16'h0000);
    rd(16'hFE08, d, h); chk("R2 unmapped data", d, 0); chk("R2 unmapped hit", h, 0);
  endtask

  task automatic t_input();
    logic [15:0] d; logic h;
    offer(8'h41);
    rd(16'hFE00, d, h); chk("R3 status", d, 16'h8000);
    rd(16'hFE00, d, h); chk("R5 status read keeps lock", d, 16'h8000);
    offer(8'h42); offer(8'h43);
    rd(16'hFE02, d, h); chk("R4 first kept", d, 16'h0041);
    rd(16'hFE00, d, h); chk("R5 cleared", d, 16'h0000);
    offer(8'h5A);
    rd(16'hFE00, d, h); chk("R5 accepts again", d, 16'h8000);
    rd(16'hFE02, d, h); chk("R3 data", d, 16'h005A);
  endtask

  task automatic t_output();
    logic [15:0] d; logic h; int s0;
    s0 = sends;
    wr(16'hFE06, 16'hAB61);
    chk("R6 one pulse", sends - s0, 1); chk("R6 char", last_sent, 8'h61);
    rd(16'hFE04, d, h); chk("R6 busy", d, 16'h0000);
    wr(16'hFE06, 16'h0062);
    chk("R7 dropped", sends - s0, 1);
    ack();
    rd(16'hFE04, d, h); chk("R8 ready", d, 16'h8000);
    wr(16'hFE06, 16'h0063);
    chk("R8 after ack", sends - s0, 2); chk("R6 char2", last_sent, 8'h63);
    ack();
  endtask

  task automatic t_stray();
    logic [15:0] d; logic h;
    offer(8'h37);
    wr(16'hFE00, 16'h0000); wr(16'hFE02, 16'h00FF); wr(16'hFE04, 16'h0000);
    rd(16'hFE00, d, h); chk("R9 kstat", d, 16'h8000);
    rd(16'hFE04, d, h); chk("R9 dstat", d, 16'h8000);
    rd(16'hFE02, d, h); chk("R9 kdata", d, 16'h0037);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset(); t_input(); t_output(); t_stray();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule